// File: doc/BRIEF.md
# Cascadeable Serial Fault Register

This block collects fault events from the protection logic of a six-channel low-side driver and holds them as sticky flags. There is one thermal flag. Each channel also has three flags: overload, open load and short to ground. A host reads the flags through a serial port made of a chip select, a serial clock, a data input and a data output. Reading is destructive. The first serial clock rising edge of a transfer clears the stored flags. A flag is therefore seen exactly once, in the first frame read after it was raised.

Several devices can share one host port by chaining them. Each device's data input takes the data output of the next device down the chain. Once the local frame has been shifted out, the data received on the input follows on the output. The host therefore reads the whole chain as one long word.

The serial inputs are oversampled by the block clock. The serial clock is assumed slow enough that each of its phases lasts at least three block-clock cycles.

Top module: `fault_chain_reg`

## Requirements
- R1: Driving `rst_n` low clears every stored flag and drives `sdo` low at once. The first frame read after reset is all zero.
- R2: The frame is 1+3*NUM_CH bits (19 by default) and is sent first bit first. The order is fixed:
  - the thermal flag comes first;
  - then one 3-bit group per channel, from channel NUM_CH down to channel 1;
  - inside each group the order is overload, open load, short to ground.
- R3: A one-cycle event pulse sets its flag, and the flag stays set until a transfer reads it.
- R4: The first `sclk` rising edge after `cs_n` falls clears every flag. A second read with no new events returns all zero.
- R5: The frame content is captured when `cs_n` falls. An event that arrives during a transfer, after the clearing edge, is absent from that frame and appears in the next one.
- R6: An event arriving in the same block-clock cycle as the clearing action is kept, and it appears in the next frame.
- R7: Data on `sdi` is shifted in on each `sclk` rising edge. After the local frame, those bits appear on `sdo` in the order they were received.
- R8: `sdo` is low while `cs_n` is high.
- R9: `sclk` edges while `cs_n` is high neither clear nor alter the stored flags.
- R10: `sdo` changes only after a falling edge of `sclk`, or at capture. Output bit k is valid before the k-th rising edge of `sclk`. Serial inputs pass through SYNC_STAGES (2) synchronizer flops. The clearing action therefore lands on the third block-clock rising edge after `sclk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial port |
| rst_n | input | 1 | Asynchronous active-low clear and reset |
| cs_n | input | 1 | Active-low transfer select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Chain data from the next device down |
| therm_ev | input | 1 | Thermal overload event pulse |
| ovl_ev | input | NUM_CH | Overload event pulse per channel (bit 0 = channel 1) |
| opn_ev | input | NUM_CH | Open-load event pulse per channel |
| gnd_ev | input | NUM_CH | Short-to-ground event pulse per channel |
| sdo | output | 1 | Serial data toward the host |

## Verification
The hardest case to reach from the ports is an event that lands in the exact block-clock cycle where the first serial rising edge clears the register. If the bench gets that cycle wrong, it only tests R4 or R5, not R6. The bench's transfer task can inject an event at a chosen serial clock edge. For the first edge, it raises `sclk` on a falling block-clock edge, counts two rising edges through the synchronizer, then holds the event for exactly the third one. It then checks that the current frame lacks the event and that the next frame shows it alone.

// File: rtl/fault_chain_pkg.sv
package fault_chain_pkg;

  // bit offsets of the three faults inside one channel group
  localparam int unsigned OFS_GND  = 0;
  localparam int unsigned OFS_OPEN = 1;
  localparam int unsigned OFS_OVL  = 2;
  localparam int unsigned GRP_W    = 3;

  function automatic int unsigned frame_width(input int unsigned nch);
    return 1 + GRP_W * nch;
  endfunction

endpackage

// File: rtl/fcr_sync.sv
module fcr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q   [STAGES];
  logic [W-1:0] stg_nxt [STAGES];

  always_comb begin
    stg_nxt[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_nxt[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_nxt[s];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/fcr_edge.sv
module fcr_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic prev_q;

  fcr_sync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/fcr_sticky.sv
module fcr_sticky
  import fault_chain_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  localparam int unsigned FW    = frame_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              therm_ev,
  input  logic [NUM_CH-1:0] ovl_ev,
  input  logic [NUM_CH-1:0] opn_ev,
  input  logic [NUM_CH-1:0] gnd_ev,
  input  logic              clr,
  output logic [FW-1:0]     frame
);

  logic [FW-1:0] ev_vec;
  logic [FW-1:0] flags_q;
  logic [FW-1:0] flags_nxt;

  assign ev_vec[FW-1] = therm_ev;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign ev_vec[GRP_W*c + OFS_OVL]  = ovl_ev[c];
    assign ev_vec[GRP_W*c + OFS_OPEN] = opn_ev[c];
    assign ev_vec[GRP_W*c + OFS_GND]  = gnd_ev[c];
  end

  // a clear drops old flags but keeps events of the same cycle
  always_comb begin
    flags_nxt = (clr ? '0 : flags_q) | ev_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nxt;
  end

  assign frame = flags_q;

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((frame & $past(frame)) == $past(frame)));

  // R6
  clear_keeps_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (frame == $past(ev_vec)));

endmodule

// File: rtl/fcr_shifter.sv
module fcr_shifter #(
  parameter int unsigned W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         start,
  input  logic         stop,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         sdi,
  input  logic [W-1:0] frame,
  output logic         clr,
  output logic         sdo
);

  logic [W-1:0] shreg_q, shreg_nxt;
  logic         obit_q, obit_nxt;
  logic         armed_q, armed_nxt;
  logic         shift_en;

  assign shift_en = sel & sck_rise & ~start;

  always_comb begin
    shreg_nxt = shreg_q;
    obit_nxt  = obit_q;
    armed_nxt = armed_q;

    if (start)         shreg_nxt = frame;
    else if (shift_en) shreg_nxt = {shreg_q[W-2:0], sdi};

    if (!sel)          obit_nxt = 1'b0;
    else if (start)    obit_nxt = frame[W-1];
    else if (sck_fall) obit_nxt = shreg_q[W-1];

    if (start)                 armed_nxt = 1'b1;
    else if (stop || shift_en) armed_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      obit_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      shreg_q <= shreg_nxt;
      obit_q  <= obit_nxt;
      armed_q <= armed_nxt;
    end
  end

  assign clr = shift_en & armed_q;
  assign sdo = obit_q;

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !sdo);

  // R5
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (shreg_q == $past(frame)));

  // R7
  chain_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (shreg_q[0] == $past(sdi)));

  // R9
  no_clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !clr);

endmodule

// File: rtl/fault_chain_reg.sv
module fault_chain_reg
  import fault_chain_pkg::*;
#(
  parameter int unsigned NUM_CH      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              therm_ev,
  input  logic [NUM_CH-1:0] ovl_ev,
  input  logic [NUM_CH-1:0] opn_ev,
  input  logic [NUM_CH-1:0] gnd_ev,
  output logic              sdo
);

  localparam int unsigned FW = frame_width(NUM_CH);

  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          sel, sel_start, sel_stop;
  logic          sck_lvl, sck_rise, sck_fall;
  logic          sdi_s;
  logic          clr;
  logic [FW-1:0] frame;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  fcr_edge #(.STAGES(SYNC_STAGES)) u_sel_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .raw   (~cs_n),
    .lvl   (sel),
    .rise  (sel_start),
    .fall  (sel_stop)
  );

  fcr_edge #(.STAGES(SYNC_STAGES)) u_sck_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .raw   (sclk),
    .lvl   (sck_lvl),
    .rise  (sck_rise),
    .fall  (sck_fall)
  );

  fcr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sdi_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (sdi),
    .q     (sdi_s)
  );

  fcr_sticky #(.NUM_CH(NUM_CH)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .therm_ev (therm_ev),
    .ovl_ev   (ovl_ev),
    .opn_ev   (opn_ev),
    .gnd_ev   (gnd_ev),
    .clr      (clr),
    .frame    (frame)
  );

  fcr_shifter #(.W(FW)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel      (sel),
    .start    (sel_start),
    .stop     (sel_stop),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sdi      (sdi_s),
    .frame    (frame),
    .clr      (clr),
    .sdo      (sdo)
  );

  // R4
  clr_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr |-> (sel && sck_lvl));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !sdo);

endmodule

// File: tb/tb_fault_chain_reg.sv
module tb_fault_chain_reg;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n;
  logic       sclk;
  logic       sdi;
  logic       therm_ev;
  logic [5:0] ovl_ev, opn_ev, gnd_ev;
  logic       sdo;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fault_chain_reg dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdi      (sdi),
    .therm_ev (therm_ev),
    .ovl_ev   (ovl_ev),
    .opn_ev   (opn_ev),
    .gnd_ev   (gnd_ev),
    .sdo      (sdo)
  );

  // entry: {therm, ovl[6], opn[6], gnd[6], chain byte}
  localparam logic [26:0] VEC [6] = '{
    {1'b1, 6'h00, 6'h00, 6'h00, 8'hA5},
    {1'b0, 6'h20, 6'h00, 6'h00, 8'h3C},
    {1'b0, 6'h00, 6'h01, 6'h00, 8'hFF},
    {1'b0, 6'h15, 6'h2A, 6'h00, 8'h00},
    {1'b1, 6'h3F, 6'h3F, 6'h3F, 8'h81},
    {1'b0, 6'h00, 6'h00, 6'h21, 8'h5A}
  };

  // R2 ordering: thermal, then channel 6 .. 1 as ovl, open, gnd
  function automatic logic [18:0] exp_frame(input logic t, input logic [5:0] o,
                                            input logic [5:0] p, input logic [5:0] g);
    logic [18:0] f;
    f[18] = t;
    for (int ch = 6; ch >= 1; ch--) begin
      int base;
      base = 17 - 3 * (6 - ch);
      f[base]   = o[ch-1];
      f[base-1] = p[ch-1];
      f[base-2] = g[ch-1];
    end
    return f;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_ev(input logic t, input logic [5:0] o, input logic [5:0] p,
                          input logic [5:0] g);
    @(negedge clk);
    therm_ev = t; ovl_ev = o; opn_ev = p; gnd_ev = g;
    @(negedge clk);
    therm_ev = 1'b0; ovl_ev = '0; opn_ev = '0; gnd_ev = '0;
    repeat (2) @(negedge clk);
  endtask

  // one 27-bit transfer; optional event injected at rising edge number ev_at,
  // aligned with the third clk edge after sclk rises (R10)
  task automatic xfer(input logic [7:0] chain, input int ev_at, input logic et,
                      input logic [5:0] eo, input logic [5:0] ep, input logic [5:0] eg,
                      output logic [26:0] got);
    got = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 27; i++) begin
      sdi = (i < 8) ? chain[7-i] : 1'b0;
      @(negedge clk);
      got = {got[25:0], sdo};
      sclk = 1'b1;
      if (i == ev_at) begin
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        therm_ev = et; ovl_ev = eo; opn_ev = ep; gnd_ev = eg;
        @(posedge clk); @(negedge clk);
        therm_ev = 1'b0; ovl_ev = '0; opn_ev = '0; gnd_ev = '0;
        @(negedge clk);
      end else begin
        repeat (4) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1;
    sdi  = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [26:0] got;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    therm_ev = 1'b0; ovl_ev = '0; opn_ev = '0; gnd_ev = '0;
    repeat (3) @(negedge clk);
    check("R1 sdo in reset", {31'd0, sdo}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(8'h00, -1, 1'b0, '0, '0, '0, got);
    check("R1 frame after reset", {13'd0, got[26:8]}, 32'd0);

    // table walk: R2, R3, R7, then R4 follow-up read
    for (int v = 0; v < 6; v++) begin
      logic [26:0] e;
      e = VEC[v];
      pulse_ev(e[26], e[25:20], e[19:14], e[13:8]);
      repeat (10) @(negedge clk);
      xfer(e[7:0], -1, 1'b0, '0, '0, '0, got);
      check("R2 R3 frame", {13'd0, got[26:8]},
            {13'd0, exp_frame(e[26], e[25:20], e[19:14], e[13:8])});
      check("R7 chain", {24'd0, got[7:0]}, {24'd0, e[7:0]});
      xfer(8'h00, -1, 1'b0, '0, '0, '0, got);
      check("R4 second read empty", {5'd0, got}, 32'd0);
    end

    // R8 and R9: clock activity with select inactive
    pulse_ev(1'b0, 6'h04, 6'h00, 6'h00);
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; repeat (4) @(negedge clk);
      check("R8 sdo idle", {31'd0, sdo}, 32'd0);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    xfer(8'h00, -1, 1'b0, '0, '0, '0, got);
    check("R9 flag survives idle sclk", {13'd0, got[26:8]},
          {13'd0, exp_frame(1'b0, 6'h04, 6'h00, 6'h00)});

    // R5: event mid-transfer
    xfer(8'h00, 5, 1'b1, '0, '0, '0, got);
    check("R5 not in current frame", {13'd0, got[26:8]}, 32'd0);
    xfer(8'h00, -1, 1'b0, '0, '0, '0, got);
    check("R5 in next frame", {13'd0, got[26:8]},
          {13'd0, exp_frame(1'b1, '0, '0, '0)});

    // R6: event in the clearing cycle
    pulse_ev(1'b0, 6'h20, 6'h00, 6'h00);
    xfer(8'h00, 0, 1'b0, '0, '0, 6'h01, got);
    check("R6 current frame old flag", {13'd0, got[26:8]},
          {13'd0, exp_frame(1'b0, 6'h20, '0, '0)});
    xfer(8'h00, -1, 1'b0, '0, '0, '0, got);
    check("R6 kept event only", {13'd0, got[26:8]},
          {13'd0, exp_frame(1'b0, '0, '0, 6'h01)});

    // R1: asynchronous clear while flags are held
    pulse_ev(1'b1, 6'h3F, 6'h00, 6'h00);
    #3 rst_n = 1'b0;
    #5 check("R1 sdo async", {31'd0, sdo}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(8'h00, -1, 1'b0, '0, '0, '0, got);
    check("R1 clear drops flags", {13'd0, got[26:8]}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule